// File: doc/BRIEF.md
# Big-Endian Bus Width Adapter

This block sits between a 32-bit master port and a single target whose native port width is one, two or four bytes. A master request names a byte address, an access size of one, two or four bytes, a direction and, for writes, the data. The adapter turns it into a sequence of native beats on the target side, using big-endian lane order: the byte at the lowest address always sits in the most significant position. An access wider than the target is split into several beats at rising addresses. An access narrower than the target uses one beat on the aligned container. A narrow write to a wider target reads the container, replaces only the addressed lane and writes the container back.

Before any beat is issued, the adapter checks the request. A misaligned request ends with an alignment fault. A request to an address the surrounding decoder reports as unmapped, a request with an unsupported target width code or a request with the reserved size code ends with a bus error. A faulted request never reaches the target. A running cost meter adds the configured target read or write latency for every charged beat. This gives the number of wait cycles the traffic would cost at the target.

Top module: `be_width_adapter`

## Requirements
- R1: A read of S bytes from a target of G bytes with S >= G issues S/G read beats at addr, addr+G, and so on. The beat from the lowest address lands in the most significant part of the result. The result is right-justified in m_rdata (byte in bits 7:0, halfword in 15:0) and the unused upper bits are zero.
- R2: A read narrower than the target issues one read beat at the container address (addr with its low bits cleared to a multiple of G). It returns the addressed lane, found by shifting the container right by 8*(G-S-(addr mod G)) and masking to S bytes.
- R3: A write of S bytes to a target of G bytes with S >= G issues S/G write beats at rising addresses. The most significant G bytes of the data go first. Target bytes outside the addressed range are left unchanged.
- R4: A write narrower than the target is done as one read beat followed by one write beat to the same container address. The write beat carries the read container with only the addressed S-byte lane replaced.
- R5: cost_cnt starts at zero after reset. It adds cfg_rd_lat for every read beat of a read request and cfg_wr_lat for every write beat. The read beat of a read-modify-write is not charged, and a faulted request adds nothing.
- R6: A 4-byte request (m_size=2) with m_addr[1:0] != 0, or a 2-byte request (m_size=1) with m_addr[0] = 1, ends with m_align_fault and issues no target beat.
- R7: A request with m_mapped low ends with m_bus_err and issues no target beat. This holds for reads and writes. When the request is also misaligned, only m_align_fault is raised.
- R8: A cfg_gran value other than 1, 2 or 4 (a byte count), or the reserved size code m_size=3, ends with m_bus_err and issues no target beat.
- R9: m_ack is high for exactly one cycle. For a request taken in cycle c, m_ack rises N+1 clock edges after the request is seen, where N is the number of target beats (0 for a faulted request). Size codes: 0 byte, 1 halfword, 2 word.
- R10: While rst is high and after it is released, m_ack, t_stb, m_align_fault, m_bus_err and cost_cnt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request, held until m_ack |
| m_we | input | 1 | 1 for write, 0 for read |
| m_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| m_addr | input | ADDR_W | Byte address |
| m_wdata | input | 32 | Write data, right-justified |
| m_mapped | input | 1 | The address decoder found a target for m_addr |
| m_ack | output | 1 | One-cycle completion pulse |
| m_rdata | output | 32 | Read result, right-justified, valid with m_ack on reads |
| m_align_fault | output | 1 | Alignment fault, valid with m_ack |
| m_bus_err | output | 1 | Bus error, valid with m_ack |
| cfg_gran | input | 3 | Target native width in bytes (1, 2 or 4) |
| cfg_rd_lat | input | LAT_W | Target read latency in cycles |
| cfg_wr_lat | input | LAT_W | Target write latency in cycles |
| t_stb | output | 1 | Target beat strobe, one cycle per beat |
| t_we | output | 1 | Target beat is a write |
| t_addr | output | ADDR_W | Target beat byte address, aligned to cfg_gran |
| t_wdata | output | 32 | Target write data, right-justified in cfg_gran bytes |
| t_rdata | input | 32 | Target read data, right-justified, valid in the strobe cycle |
| cost_cnt | output | CNT_W | Accumulated target wait cycles |

## Verification
The assertions assume that the master holds m_req and its qualifiers steady from the request until m_ack. They also assume that cfg_gran does not change while a request is in flight, and that the target returns t_rdata in the same cycle as a read strobe. The bench drives every request through one task that keeps the request fields constant until it sees m_ack and then drops m_req. It changes the configuration only between requests. Its target model answers reads combinationally from a byte array. Beat addresses stay well below the top of that array, so no beat sequence wraps.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = 8 * BUS_BYTES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // Per-request shape, latched when the request is taken.
    typedef struct packed {
        logic [2:0] gbytes;   // native target width in bytes
        logic [2:0] sbytes;   // access size in bytes
        logic       narrow;   // access narrower than target
        logic [5:0] lane_sh;  // bit offset of the lane inside the container
    } plan_t;

    function automatic logic [2:0] size_bytes(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return BUS_W'(32'h0000_00ff);
            3'd2:    return BUS_W'(32'h0000_ffff);
            3'd4:    return '1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bwa_planner.sv
module bwa_planner
    import bwa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        gran_code,
    input  logic              mapped,
    output plan_t             plan,
    output logic [2:0]        n_beats,
    output logic [ADDR_W-1:0] base,
    output logic              align_err,
    output logic              bus_err
);

    logic [2:0] sb;
    logic [2:0] gb;
    logic       gvalid;
    logic [1:0] gm;
    logic [1:0] off;
    logic [2:0] diff;
    logic       narrow;

    always_comb begin
        sb     = size_bytes(acc_size_e'(size));
        gvalid = (gran_code == 3'd1) || (gran_code == 3'd2) || (gran_code == 3'd4);
        gb     = gvalid ? gran_code : 3'd4;

        align_err = ((sb == 3'd4) && (addr[1:0] != 2'b00)) ||
                    ((sb == 3'd2) && addr[0]);
        bus_err   = !align_err && (!mapped || !gvalid || (sb == 3'd0));

        gm     = gb[1:0] - 2'd1;          // 1->00, 2->01, 4->11
        off    = addr[1:0] & gm;
        narrow = sb < gb;
        diff   = gb - sb - {1'b0, off};

        plan.gbytes  = gb;
        plan.sbytes  = sb;
        plan.narrow  = narrow;
        plan.lane_sh = narrow ? {diff, 3'b000} : 6'd0;

        case (gb)
            3'd1:    n_beats = sb;
            3'd2:    n_beats = narrow ? 3'd1 : {1'b0, sb[2:1]};
            default: n_beats = 3'd1;
        endcase

        base = narrow ? (addr & ~ADDR_W'(gm)) : addr;
    end

endmodule

// File: rtl/bwa_lanes.sv
module bwa_lanes
    import bwa_pkg::*;
(
    input  plan_t            plan,
    input  logic [BUS_W-1:0] acc,
    input  logic [BUS_W-1:0] wsh,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] t_rdata,
    output logic [BUS_W-1:0] asm_next,
    output logic [BUS_W-1:0] ext_val,
    output logic [BUS_W-1:0] merged,
    output logic [BUS_W-1:0] beat_wd,
    output logic [BUS_W-1:0] wsh_next
);

    logic [BUS_W-1:0] gmask;
    logic [BUS_W-1:0] smask;
    logic [5:0]       shw;

    always_comb begin
        gmask = lane_mask(plan.gbytes);
        smask = lane_mask(plan.sbytes);
        shw   = {plan.gbytes, 3'b000};

        // wide read: shift earlier beats up, new beat into the low lane
        asm_next = (acc << shw) | (t_rdata & gmask);
        // narrow read: pick the addressed lane out of the container
        ext_val  = (t_rdata >> plan.lane_sh) & smask;
        // narrow write: container with one lane replaced
        merged   = (t_rdata & gmask & ~(smask << plan.lane_sh)) |
                   ((wdata & smask) << plan.lane_sh);
        // wide write: the top G bytes of the left-justified data go out next
        beat_wd  = wsh >> (6'd32 - shw);
        wsh_next = wsh << shw;
    end

endmodule

// File: rtl/bwa_cost_meter.sv
module bwa_cost_meter #(
    parameter int CNT_W = 32,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             charge,
    input  logic [LAT_W-1:0] amount,
    output logic [CNT_W-1:0] total
);

    always_ff @(posedge clk) begin
        if (rst) begin
            total <= '0;
        end else if (charge) begin
            total <= total + CNT_W'(amount);
        end
    end

endmodule

// File: rtl/be_width_adapter.sv
module be_width_adapter
    import bwa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LAT_W  = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [1:0]        m_size,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [31:0]       m_wdata,
    input  logic              m_mapped,
    output logic              m_ack,
    output logic [31:0]       m_rdata,
    output logic              m_align_fault,
    output logic              m_bus_err,
    input  logic [2:0]        cfg_gran,
    input  logic [LAT_W-1:0]  cfg_rd_lat,
    input  logic [LAT_W-1:0]  cfg_wr_lat,
    output logic              t_stb,
    output logic              t_we,
    output logic [ADDR_W-1:0] t_addr,
    output logic [31:0]       t_wdata,
    input  logic [31:0]       t_rdata,
    output logic [CNT_W-1:0]  cost_cnt
);

    // ---------------- request planning ----------------
    plan_t             pl;
    logic [2:0]        pl_beats;
    logic [ADDR_W-1:0] pl_base;
    logic              pl_align;
    logic              pl_bus;

    bwa_planner #(.ADDR_W(ADDR_W)) u_plan (
        .size      (m_size),
        .addr      (m_addr),
        .gran_code (cfg_gran),
        .mapped    (m_mapped),
        .plan      (pl),
        .n_beats   (pl_beats),
        .base      (pl_base),
        .align_err (pl_align),
        .bus_err   (pl_bus)
    );

    // ---------------- sequencer state ----------------
    phase_e            ph;
    plan_t             pl_q;
    logic              we_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [2:0]        beats_left;
    logic [BUS_W-1:0]  acc;
    logic [BUS_W-1:0]  wsh;
    logic [BUS_W-1:0]  wd_q;
    logic              align_q;
    logic              bus_q;

    logic [BUS_W-1:0] asm_next;
    logic [BUS_W-1:0] ext_val;
    logic [BUS_W-1:0] merged;
    logic [BUS_W-1:0] beat_wd;
    logic [BUS_W-1:0] wsh_next;
    logic [BUS_W-1:0] wsh_init;
    logic             last_beat;

    bwa_lanes u_lanes (
        .plan     (pl_q),
        .acc      (acc),
        .wsh      (wsh),
        .wdata    (wd_q),
        .t_rdata  (t_rdata),
        .asm_next (asm_next),
        .ext_val  (ext_val),
        .merged   (merged),
        .beat_wd  (beat_wd),
        .wsh_next (wsh_next)
    );

    always_comb begin
        wsh_init  = m_wdata << {(3'd4 - pl.sbytes), 3'b000};
        last_beat = (beats_left == 3'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            pl_q       <= '0;
            we_q       <= 1'b0;
            cur_addr   <= '0;
            beats_left <= '0;
            acc        <= '0;
            wsh        <= '0;
            wd_q       <= '0;
            align_q    <= 1'b0;
            bus_q      <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (m_req) begin
                        pl_q       <= pl;
                        we_q       <= m_we;
                        cur_addr   <= pl_base;
                        beats_left <= pl_beats;
                        acc        <= '0;
                        wsh        <= wsh_init;
                        wd_q       <= m_wdata;
                        align_q    <= pl_align;
                        bus_q      <= pl_bus;
                        if (pl_align || pl_bus) begin
                            ph <= PH_DONE;
                        end else if (!m_we || pl.narrow) begin
                            ph <= PH_RD;
                        end else begin
                            ph <= PH_WR;
                        end
                    end
                end
                PH_RD: begin
                    if (pl_q.narrow) begin
                        // read-modify-write keeps the merged container in acc
                        acc <= we_q ? merged : ext_val;
                        ph  <= we_q ? PH_WR : PH_DONE;
                    end else begin
                        acc        <= asm_next;
                        cur_addr   <= cur_addr + ADDR_W'(pl_q.gbytes);
                        beats_left <= beats_left - 3'd1;
                        if (last_beat) begin
                            ph <= PH_DONE;
                        end
                    end
                end
                PH_WR: begin
                    wsh        <= wsh_next;
                    cur_addr   <= cur_addr + ADDR_W'(pl_q.gbytes);
                    beats_left <= beats_left - 3'd1;
                    if (last_beat) begin
                        ph <= PH_DONE;
                    end
                end
                default: begin
                    ph <= PH_IDLE;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        t_stb         = (ph == PH_RD) || (ph == PH_WR);
        t_we          = (ph == PH_WR);
        t_addr        = cur_addr;
        t_wdata       = pl_q.narrow ? acc : beat_wd;
        m_ack         = (ph == PH_DONE);
        m_rdata       = acc;
        m_align_fault = m_ack && align_q;
        m_bus_err     = m_ack && bus_q;
    end

    // ---------------- cost accounting ----------------
    logic             charge;
    logic [LAT_W-1:0] charge_amt;

    always_comb begin
        charge     = (ph == PH_WR) || ((ph == PH_RD) && !we_q);
        charge_amt = (ph == PH_WR) ? cfg_wr_lat : cfg_rd_lat;
    end

    bwa_cost_meter #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_cost (
        .clk    (clk),
        .rst    (rst),
        .charge (charge),
        .amount (charge_amt),
        .total  (cost_cnt)
    );

    // ---------------- assertions ----------------
    a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
        m_ack |=> !m_ack);

    a_r6_no_beat_on_align: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && m_req && pl_align) |=> !t_stb);

    a_r7_no_beat_on_buserr: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && m_req && pl_bus) |=> !t_stb);

    a_r7_align_wins: assert property (@(posedge clk) disable iff (rst)
        m_align_fault |-> !m_bus_err);

    a_r4_read_before_write: assert property (@(posedge clk) disable iff (rst)
        (t_stb && t_we && pl_q.narrow) |-> $past(t_stb && !t_we));

    a_r1_beat_aligned: assert property (@(posedge clk) disable iff (rst)
        t_stb |-> ((t_addr[2:0] & (pl_q.gbytes - 3'd1)) == 3'd0));

    a_r5_cost_idle: assert property (@(posedge clk) disable iff (rst)
        !t_stb |=> $stable(cost_cnt));

    a_r10_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!m_ack && !t_stb && cost_cnt == '0));

endmodule

// File: tb/be_width_adapter_test.sv
module be_width_adapter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_req = 1'b0;
    logic        m_we = 1'b0;
    logic [1:0]  m_size = 2'd0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        m_mapped = 1'b1;
    logic        m_ack;
    logic [31:0] m_rdata;
    logic        m_align_fault;
    logic        m_bus_err;
    logic [2:0]  cfg_gran = 3'd4;
    logic [7:0]  cfg_rd_lat = 8'd3;
    logic [7:0]  cfg_wr_lat = 8'd5;
    logic        t_stb;
    logic        t_we;
    logic [31:0] t_addr;
    logic [31:0] t_wdata;
    logic [31:0] t_rdata;
    logic [31:0] cost_cnt;

    int checks = 0;
    int errors = 0;

    be_width_adapter uut (
        .clk(clk), .rst(rst),
        .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_mapped(m_mapped),
        .m_ack(m_ack), .m_rdata(m_rdata),
        .m_align_fault(m_align_fault), .m_bus_err(m_bus_err),
        .cfg_gran(cfg_gran), .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
        .t_stb(t_stb), .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata),
        .t_rdata(t_rdata), .cost_cnt(cost_cnt)
    );

    always #5 clk = ~clk;

    // ---------------- target model: byte array, big-endian beats ----------------
    logic [7:0] mem    [256];
    logic [7:0] shadow [256];
    int stb_cnt = 0;
    int misalign_cnt = 0;

    always_comb begin
        t_rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(cfg_gran)) begin
                t_rdata = (t_rdata << 8) | 32'(mem[8'(t_addr[7:0] + 8'(k))]);
            end
        end
    end

    always @(posedge clk) begin
        if (!rst && t_stb) begin
            stb_cnt++;
            if ((int'(t_addr[1:0]) % int'(cfg_gran)) != 0) misalign_cnt++;
            if (t_we) begin
                for (int k = 0; k < 4; k++) begin
                    if (k < int'(cfg_gran)) begin
                        mem[8'(t_addr[7:0] + 8'(k))] <=
                            8'(t_wdata >> (8 * (int'(cfg_gran) - 1 - k)));
                    end
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] r_rdata;
    logic        r_align;
    logic        r_bus;
    int          r_cyc;
    int          r_stb;
    int          r_mis;
    logic [31:0] r_cost;

    task automatic xfer(input bit we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, input bit mapped);
        int s0;
        int m0;
        logic [31:0] c0;
        @(negedge clk);
        s0 = stb_cnt;
        m0 = misalign_cnt;
        c0 = cost_cnt;
        m_we = we; m_size = sz; m_addr = {24'd0, a}; m_wdata = wd;
        m_mapped = mapped; m_req = 1'b1;
        r_cyc = 0;
        do begin
            @(negedge clk);
            r_cyc++;
        end while (!m_ack && r_cyc < 40);
        r_rdata = m_rdata;
        r_align = m_align_fault;
        r_bus   = m_bus_err;
        m_req   = 1'b0;
        r_stb   = stb_cnt - s0;
        r_mis   = misalign_cnt - m0;
        r_cost  = cost_cnt - c0;
    endtask

    function automatic logic [31:0] ref_read(input logic [7:0] a, input int s);
        logic [31:0] v = '0;
        for (int k = 0; k < s; k++) v = (v << 8) | 32'(shadow[8'(a + 8'(k))]);
        return v;
    endfunction

    task automatic shadow_write(input logic [7:0] a, input int s, input logic [31:0] wd);
        for (int k = 0; k < s; k++) shadow[8'(a + 8'(k))] = 8'(wd >> (8 * (s - 1 - k)));
    endtask

    function automatic int mem_diffs();
        int n = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) n++;
        return n;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(m_ack == 1'b0,    "R10 ack low after reset", 32'(m_ack), 0);
        chk(t_stb == 1'b0,    "R10 strobe low after reset", 32'(t_stb), 0);
        chk(cost_cnt == 0,    "R10 cost zero after reset", cost_cnt, 0);
        chk(!m_align_fault && !m_bus_err, "R10 fault flags low after reset",
            {30'd0, m_align_fault, m_bus_err}, 0);
    endtask

    // word read from byte target: four beats, lowest address in 31:24
    task automatic t_word_from_bytes();
        cfg_gran = 3'd1; cfg_rd_lat = 8'd3;
        xfer(1'b0, 2'd2, 8'h20, 32'h0, 1'b1);
        chk(r_rdata == ref_read(8'h20, 4), "R1 word from byte target data", r_rdata, ref_read(8'h20, 4));
        chk(r_rdata[31:24] == shadow[8'h20], "R1 lowest address in top byte", 32'(r_rdata[31:24]), 32'(shadow[8'h20]));
        chk(r_stb == 4, "R1 four beats", r_stb, 4);
        chk(r_cost == 12, "R5 cost is 4 x read latency", r_cost, 12);
        chk(r_cyc == 5, "R9 ack after beats plus one", r_cyc, 5);
    endtask

    // all size and width pairs, reads then writes
    task automatic t_matrix();
        cfg_rd_lat = 8'd2; cfg_wr_lat = 8'd7;
        for (int gi = 0; gi < 3; gi++) begin
            for (int si = 0; si < 3; si++) begin
                int g = 1 << gi;
                int s = 1 << si;
                logic [7:0] a = 8'(8'h40 + 16 * (3 * gi + si) + ((s == 1) ? 3 : (s == 2) ? 2 : 0));
                int nbr = (s >= g) ? s / g : 1;
                int nbw = (s >= g) ? s / g : 2;
                logic [31:0] wv = 32'hA5C3_1E70 ^ 32'(a * 97);
                logic [31:0] wexp;
                string rt = (s >= g) ? "R1" : "R2";
                string wt = (s >= g) ? "R3" : "R4";
                cfg_gran = 3'(g);
                xfer(1'b0, 2'(si), a, 32'h0, 1'b1);
                chk(r_rdata == ref_read(a, s), $sformatf("%s read g=%0d s=%0d data", rt, g, s), r_rdata, ref_read(a, s));
                chk(r_stb == nbr && r_mis == 0, $sformatf("%s read g=%0d s=%0d beats", rt, g, s), r_stb, nbr);
                chk(r_cost == 32'(nbr * 2), $sformatf("R5 read g=%0d s=%0d cost", g, s), r_cost, 32'(nbr * 2));
                chk(r_cyc == nbr + 1, $sformatf("R9 read g=%0d s=%0d latency", g, s), r_cyc, nbr + 1);
                wexp = (s == 4) ? wv : (s == 2) ? {16'd0, wv[15:0]} : {24'd0, wv[7:0]};
                xfer(1'b1, 2'(si), a, wv, 1'b1);
                shadow_write(a, s, wexp);
                chk(mem_diffs() == 0, $sformatf("%s write g=%0d s=%0d memory", wt, g, s), mem_diffs(), 0);
                chk(r_stb == nbw && r_mis == 0, $sformatf("%s write g=%0d s=%0d beats", wt, g, s), r_stb, nbw);
                chk(r_cost == 32'(((s >= g) ? s / g : 1) * 7),
                    $sformatf("R5 write g=%0d s=%0d cost", g, s), r_cost, 32'(((s >= g) ? s / g : 1) * 7));
                chk(r_cyc == nbw + 1, $sformatf("R9 write g=%0d s=%0d latency", g, s), r_cyc, nbw + 1);
            end
        end
    endtask

    // byte lanes of a word target, every offset, read then RMW write
    task automatic t_word_lanes();
        cfg_gran = 3'd4; cfg_rd_lat = 8'd1; cfg_wr_lat = 8'd4;
        for (int off = 0; off < 4; off++) begin
            logic [7:0] a = 8'(8'hB0 + off);
            logic [31:0] cont = ref_read(8'hB0, 4);
            logic [31:0] ex = (cont >> (8 * (3 - off))) & 32'hff;
            xfer(1'b0, 2'd0, a, 32'h0, 1'b1);
            chk(r_rdata == ex, $sformatf("R2 byte lane %0d of word", off), r_rdata, ex);
            xfer(1'b1, 2'd0, a, 32'hFFFF_FF00 | 32'(8'h11 * (off + 1)), 1'b1);
            shadow_write(a, 1, 32'(8'h11 * (off + 1)));
            chk(mem_diffs() == 0, $sformatf("R4 byte RMW lane %0d", off), mem_diffs(), 0);
            chk(r_cost == 4, $sformatf("R5 RMW read beat uncharged lane %0d", off), r_cost, 4);
        end
    endtask

    task automatic t_faults();
        logic [31:0] c0;
        cfg_gran = 3'd1;
        xfer(1'b1, 2'd2, 8'h61, 32'hDEAD_BEEF, 1'b1);
        chk(r_align && !r_bus && r_stb == 0, "R6 misaligned word write", {r_align, r_bus, 30'(r_stb)}, 32'h8000_0000);
        chk(mem_diffs() == 0, "R6 misaligned write leaves target", mem_diffs(), 0);
        chk(r_cyc == 1, "R9 faulted ack latency", r_cyc, 1);
        cfg_gran = 3'd4;
        xfer(1'b0, 2'd1, 8'h63, 32'h0, 1'b1);
        chk(r_align && !r_bus && r_stb == 0, "R6 misaligned half read", {r_align, r_bus, 30'(r_stb)}, 32'h8000_0000);
        c0 = cost_cnt;
        xfer(1'b1, 2'd1, 8'h62, 32'h0000_1234, 1'b0);
        chk(r_bus && !r_align && r_stb == 0, "R7 unmapped write", {r_align, r_bus, 30'(r_stb)}, 32'h4000_0000);
        chk(mem_diffs() == 0, "R7 unmapped write leaves target", mem_diffs(), 0);
        xfer(1'b0, 2'd2, 8'h60, 32'h0, 1'b0);
        chk(r_bus && r_stb == 0, "R7 unmapped read", {r_align, r_bus, 30'(r_stb)}, 32'h4000_0000);
        xfer(1'b0, 2'd2, 8'h62, 32'h0, 1'b0);
        chk(r_align && !r_bus, "R7 alignment wins over unmapped", {r_align, r_bus, 30'(r_stb)}, 32'h8000_0000);
        cfg_gran = 3'd3;
        xfer(1'b1, 2'd0, 8'h60, 32'h55, 1'b1);
        chk(r_bus && r_stb == 0, "R8 width code 3", {r_align, r_bus, 30'(r_stb)}, 32'h4000_0000);
        cfg_gran = 3'd0;
        xfer(1'b0, 2'd0, 8'h60, 32'h0, 1'b1);
        chk(r_bus && r_stb == 0, "R8 width code 0", {r_align, r_bus, 30'(r_stb)}, 32'h4000_0000);
        cfg_gran = 3'd2;
        xfer(1'b1, 2'd3, 8'h60, 32'h77, 1'b1);
        chk(r_bus && r_stb == 0, "R8 reserved size code", {r_align, r_bus, 30'(r_stb)}, 32'h4000_0000);
        chk(mem_diffs() == 0, "R8 rejected write leaves target", mem_diffs(), 0);
        chk(cost_cnt == c0, "R5 faults add no cost", cost_cnt, c0);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cost_cnt == 0, "R10 cost cleared by reset", cost_cnt, 0);
        chk(m_ack == 1'b0 && t_stb == 1'b0, "R10 idle after reset", {30'd0, m_ack, t_stb}, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i * 37 + 5);
            shadow[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word_from_bytes();
        t_matrix();
        t_word_lanes();
        t_faults();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule